// File: doc/BRIEF.md
# Hashing Engine Status Indicator Driver

This block turns a few internal status signals of a hashing FPGA into four LED drive outputs. The red output is a heartbeat: a divided-down copy of the hashing clock that blinks while the clock is healthy. It turns solid on as soon as the clock generator reports loss of lock, or the clock is flagged invalid. Once the clock is clean again, it restarts blinking from a fixed phase.

The green and blue outputs are event indicators. Green reacts to a found nonce. Blue reacts to a receive or transmit pulse from the serial link. An event drives the indicator fully on. Its brightness then decays in equal steps through a fixed-frequency PWM until it is dark. Another event at any point during the decay restarts it at full brightness.

The amber output shows that the engine is idle. It is lit whenever the busy flag is low.

Top module: `led_status_top`

## Requirements
- R1: While reset is high and on the first cycle after it, red, green and blue are off (with clock lock and valid high), and the fade and heartbeat counters start from zero.
- R2: With lock and valid both high, red follows bit HB_W-1 of a counter that advances once per clock. Red is therefore low for 2^(HB_W-1) cycles and high for 2^(HB_W-1) cycles, in turn.
- R3: On the clock edge after lock or valid is sampled low, red is on. It stays on at every edge where the previous edge sampled either flag low.
- R4: At the first edge where both flags are sampled high again, the heartbeat counter is 1. Red is then low for the first 2^(HB_W-1)-1 cycles and goes high on cycle 2^(HB_W-1) counted from that edge.
- R5: A one-cycle nonce pulse sets the green duty to full (2^PWM_W out of a PWM period of 2^PWM_W cycles). Green is on at the following edge and stays on for a whole PWM period unless a fade step falls inside it.
- R6: A receive pulse or a transmit pulse sets the blue duty to full in the same way.
- R7: With no new event, a channel's duty drops by exactly one every 2^TICK_W cycles and never rises. Its LED is on in a PWM period for as many cycles as its duty, and is fully dark once the duty reaches zero.
- R8: An event that arrives during a fade restores full duty on its channel at the next edge.
- R9: A nonce pulse leaves blue unchanged, and serial pulses leave green unchanged.
- R10: Amber is the inverse of busy, without any register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Hashing clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_lock | input | 1 | Clock generator lock indication |
| clk_valid | input | 1 | High while the hashing clock is judged valid |
| nonce_found | input | 1 | One-cycle pulse per found nonce |
| rx_act | input | 1 | One-cycle pulse on serial receive activity |
| tx_act | input | 1 | One-cycle pulse on serial transmit activity |
| busy | input | 1 | High while the engine is hashing |
| led_red | output | 1 | Heartbeat, solid on clock fault |
| led_green | output | 1 | Nonce indicator with fade |
| led_blue | output | 1 | Serial activity indicator with fade |
| led_amber | output | 1 | Idle indicator |

## Verification
The heartbeat is tested in two ways. A lock drop and a separate valid drop show that each flag alone forces red solid. A recovery followed by a long run of blink cycles pins both the restart phase and the half-period.

The fades are measured as on-cycles per PWM period. A single event is followed until it is dark, which shows the decay is stepwise and monotone rather than instant. A retrigger in the middle of a fade shows a jump back to full. Receive-only and transmit-only pulses, checked against the idle green channel, show that the two fade channels are independent and that both serial sources feed blue.

// File: rtl/led_pkg.sv
package led_pkg;

    typedef struct packed {
        logic red;
        logic green;
        logic blue;
        logic amber;
    } led_vec_t;

    typedef enum int {
        CH_NONCE  = 0,
        CH_SERIAL = 1
    } fade_ch_e;

    localparam int NUM_FADE = 2;

    function automatic int duty_width(input int pwm_w);
        return pwm_w + 1;
    endfunction

endpackage

// File: rtl/led_timebase.sv
module led_timebase #(
    parameter int PWM_W  = 8,
    parameter int TICK_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    output logic [PWM_W-1:0] pwm_phase,
    output logic             fade_tick
);

    logic [TICK_W-1:0] tick_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            pwm_phase <= '0;
            tick_cnt  <= '0;
        end else begin
            pwm_phase <= pwm_phase + 1'b1;
            tick_cnt  <= tick_cnt + 1'b1;
        end
    end

    // one step per full wrap of the tick counter
    assign fade_tick = &tick_cnt;

endmodule

// File: rtl/led_fader.sv
module led_fader #(
    parameter int PWM_W  = 8,
    parameter int DUTY_W = PWM_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trigger,
    input  logic              fade_tick,
    input  logic [PWM_W-1:0]  pwm_phase,
    output logic [DUTY_W-1:0] duty,
    output logic              led_on
);

    localparam logic [DUTY_W-1:0] FULL = {1'b1, {PWM_W{1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            duty <= '0;
        end else if (trigger) begin
            duty <= FULL;
        end else if (fade_tick && (duty != '0)) begin
            duty <= duty - 1'b1;
        end
    end

    assign led_on = ({1'b0, pwm_phase} < duty);

endmodule

// File: rtl/led_heartbeat.sv
module led_heartbeat #(
    parameter int HB_W = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic clk_lock,
    input  logic clk_valid,
    output logic blink,
    output logic fault
);

    logic            clean;
    logic            fault_q;
    logic [HB_W-1:0] hb_cnt;

    assign clean = clk_lock & clk_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_q <= 1'b0;
            hb_cnt  <= '0;
        end else begin
            fault_q <= ~clean;
            // held at zero during a fault so recovery starts at a fixed phase
            hb_cnt  <= clean ? hb_cnt + 1'b1 : '0;
        end
    end

    assign fault = fault_q;
    assign blink = fault_q | hb_cnt[HB_W-1];

endmodule

// File: rtl/led_status_top.sv
module led_status_top
    import led_pkg::*;
#(
    parameter int HB_W   = 25,
    parameter int PWM_W  = 8,
    parameter int TICK_W = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clk_lock,
    input  logic clk_valid,
    input  logic nonce_found,
    input  logic rx_act,
    input  logic tx_act,
    input  logic busy,
    output logic led_red,
    output logic led_green,
    output logic led_blue,
    output logic led_amber
);

    localparam int DUTY_W = duty_width(PWM_W);

    logic [PWM_W-1:0]  pwm_phase;
    logic              fade_tick;
    logic              hb_blink;
    logic              hb_fault;
    logic              trig   [NUM_FADE];
    logic              fade_on[NUM_FADE];
    logic [DUTY_W-1:0] duty   [NUM_FADE];
    logic [DUTY_W-1:0] duty_grn;
    logic [DUTY_W-1:0] duty_blu;
    led_vec_t          leds;

    assign trig[CH_NONCE]  = nonce_found;
    assign trig[CH_SERIAL] = rx_act | tx_act;

    led_timebase #(.PWM_W(PWM_W), .TICK_W(TICK_W)) u_tb (
        .clk       (clk),
        .rst       (rst),
        .pwm_phase (pwm_phase),
        .fade_tick (fade_tick)
    );

    led_heartbeat #(.HB_W(HB_W)) u_hb (
        .clk       (clk),
        .rst       (rst),
        .clk_lock  (clk_lock),
        .clk_valid (clk_valid),
        .blink     (hb_blink),
        .fault     (hb_fault)
    );

    for (genvar g = 0; g < NUM_FADE; g++) begin : g_fade
        led_fader #(.PWM_W(PWM_W), .DUTY_W(DUTY_W)) u_fade (
            .clk       (clk),
            .rst       (rst),
            .trigger   (trig[g]),
            .fade_tick (fade_tick),
            .pwm_phase (pwm_phase),
            .duty      (duty[g]),
            .led_on    (fade_on[g])
        );
    end

    assign duty_grn = duty[CH_NONCE];
    assign duty_blu = duty[CH_SERIAL];

    assign leds = '{red:   hb_blink,
                    green: fade_on[CH_NONCE],
                    blue:  fade_on[CH_SERIAL],
                    amber: ~busy};

    assign led_red   = leds.red;
    assign led_green = leds.green;
    assign led_blue  = leds.blue;
    assign led_amber = leds.amber;

endmodule

// File: rtl/led_status_chk.sv
module led_status_chk #(
    parameter int DW = 9
) (
    input logic          clk,
    input logic          rst,
    input logic          clk_lock,
    input logic          clk_valid,
    input logic          nonce_found,
    input logic          rx_act,
    input logic          tx_act,
    input logic          led_red,
    input logic          led_green,
    input logic          led_blue,
    input logic [DW-1:0] duty_grn,
    input logic [DW-1:0] duty_blu
);

    localparam logic [DW-1:0] FULL = {1'b1, {(DW-1){1'b0}}};

    p_fault_solid_r3: assert property (@(posedge clk) disable iff (rst)
        !(clk_lock && clk_valid) |=> led_red);

    p_green_full_r5: assert property (@(posedge clk) disable iff (rst)
        nonce_found |=> (led_green && duty_grn == FULL));

    p_blue_full_r6: assert property (@(posedge clk) disable iff (rst)
        (rx_act || tx_act) |=> (led_blue && duty_blu == FULL));

    p_grn_step_r7: assert property (@(posedge clk) disable iff (rst)
        !nonce_found |=> ($past(duty_grn) >= duty_grn) &&
                         (($past(duty_grn) - duty_grn) <= DW'(1)));

    p_blu_step_r7: assert property (@(posedge clk) disable iff (rst)
        !(rx_act || tx_act) |=> ($past(duty_blu) >= duty_blu) &&
                                (($past(duty_blu) - duty_blu) <= DW'(1)));

    p_grn_dark_r7: assert property (@(posedge clk) disable iff (rst)
        (duty_grn == '0) |-> !led_green);

    p_blu_dark_r7: assert property (@(posedge clk) disable iff (rst)
        (duty_blu == '0) |-> !led_blue);

endmodule

bind led_status_top led_status_chk #(.DW(DUTY_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .clk_lock    (clk_lock),
    .clk_valid   (clk_valid),
    .nonce_found (nonce_found),
    .rx_act      (rx_act),
    .tx_act      (tx_act),
    .led_red     (led_red),
    .led_green   (led_green),
    .led_blue    (led_blue),
    .duty_grn    (duty_grn),
    .duty_blu    (duty_blu)
);

// File: tb/test_led_status_top.sv
module test_led_status_top;

    localparam int HB_W   = 4;
    localparam int PWM_W  = 3;
    localparam int TICK_W = 5;
    localparam int PER    = 1 << PWM_W;
    localparam int HALF   = 1 << (HB_W - 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clk_lock = 1'b1;
    logic clk_valid = 1'b1;
    logic nonce_found = 1'b0;
    logic rx_act = 1'b0;
    logic tx_act = 1'b0;
    logic busy = 1'b1;
    logic led_red, led_green, led_blue, led_amber;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    led_status_top #(.HB_W(HB_W), .PWM_W(PWM_W), .TICK_W(TICK_W)) i_led_status_top (
        .clk         (clk),
        .rst         (rst),
        .clk_lock    (clk_lock),
        .clk_valid   (clk_valid),
        .nonce_found (nonce_found),
        .rx_act      (rx_act),
        .tx_act      (tx_act),
        .busy        (busy),
        .led_red     (led_red),
        .led_green   (led_green),
        .led_blue    (led_blue),
        .led_amber   (led_amber)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_range(input string req, input int act, input int lo, input int hi);
        n_checks++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic count_on(input bit grn, output int n);
        n = 0;
        for (int i = 0; i < PER; i++) begin
            @(negedge clk);
            if (grn ? led_green : led_blue) n++;
        end
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: nonce_found = 1'b1;
            1: rx_act = 1'b1;
            default: tx_act = 1'b1;
        endcase
        @(negedge clk);
        nonce_found = 1'b0;
        rx_act = 1'b0;
        tx_act = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1 red in reset", led_red, 0);
        check("R1 green in reset", led_green, 0);
        check("R1 blue in reset", led_blue, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 red after reset", led_red, 0);
        check("R1 green after reset", led_green, 0);
        check("R1 blue after reset", led_blue, 0);
    endtask

    task automatic t_heartbeat();
        @(negedge clk);
        clk_lock = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check("R3 solid on lock loss", led_red, 1);
        end
        clk_lock = 1'b1;
        for (int i = 1; i <= 3 * HALF; i++) begin
            @(negedge clk);
            if (i < HALF) check("R4 phase after recovery", led_red, 0);
            else check("R2 blink", led_red, ((i / HALF) % 2));
        end
        clk_valid = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R3 solid on invalid clock", led_red, 1);
        end
        clk_valid = 1'b1;
        @(negedge clk);
        check("R4 off after valid returns", led_red, 0);
    endtask

    task automatic t_green_fade();
        int cnt[40];
        int bad;
        pulse(0);
        check("R5 green on after nonce", led_green, 1);
        check("R9 blue untouched by nonce", led_blue, 0);
        for (int w = 0; w < 40; w++) count_on(1'b1, cnt[w]);
        check_range("R5 full first period", cnt[0], PER - 1, PER);
        check_range("R7 partial mid fade", cnt[16], 2, 5);
        check("R7 dark after fade", cnt[39], 0);
        bad = 0;
        for (int w = 1; w < 40; w++) if (cnt[w] > cnt[w-1]) bad++;
        check("R7 monotone decay", bad, 0);
    endtask

    task automatic t_blue_sources();
        int n;
        pulse(1);
        check("R6 blue on after rx", led_blue, 1);
        count_on(1'b0, n);
        check_range("R6 rx full period", n, PER - 1, PER);
        count_on(1'b1, n);
        check("R9 green untouched by rx", n, 0);
        repeat (300) @(negedge clk);
        pulse(2);
        check("R6 blue on after tx", led_blue, 1);
        count_on(1'b1, n);
        check("R9 green untouched by tx", n, 0);
    endtask

    task automatic t_retrigger();
        int n;
        repeat (130) @(negedge clk);
        count_on(1'b0, n);
        check_range("R8 faded before retrigger", n, 1, 5);
        pulse(1);
        count_on(1'b0, n);
        check_range("R8 full after retrigger", n, PER - 1, PER);
    endtask

    task automatic t_amber();
        @(negedge clk);
        check("R10 amber off while busy", led_amber, 0);
        busy = 1'b0;
        #1;
        check("R10 amber on when idle", led_amber, 1);
        @(negedge clk);
        busy = 1'b1;
        #1;
        check("R10 amber off again", led_amber, 0);
    endtask

    initial begin
        t_reset();
        t_heartbeat();
        t_green_fade();
        t_blue_sources();
        t_retrigger();
        t_amber();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule